// File: doc/BRIEF.md
# Multi-lane serial slave front end

This block is the pin-side half of a serial memory slave. It watches a serial clock, an active-low select and four data lanes, and it moves command, address and data bits between those lanes and a byte-wide core interface. The lane width is one, two or four bits per serial clock. It changes at run time when the host sends one of three mode opcodes. Toward the core the block delivers each received byte with a one-cycle strobe and a code for the part of the transfer that the byte belongs to. During the data phase of a read it takes bytes from the core and shifts them out.

All pins are sampled by a fast system clock through a synchronizer. Serial clock edges are found by comparing the synchronized level with its previous value. The block follows the frame structure of a transfer: an opcode byte, two address bytes, then data. On a read in two-lane or four-lane mode it holds one dummy byte period between the address and the first data byte. The lanes are modelled as separate input, output and output-enable vectors.

Top module: `mlsio_front`

## Requirements
- R1: In one-lane mode a byte is taken MSB first from lane 0, one bit per rising serial clock edge. `rx_valid` pulses once per complete byte, with `rx_phase` 0 for an opcode byte, 1 for an address byte and 4 for a write-data byte.
- R2: In two-lane mode a byte takes four rising edges. On each edge lane 1 carries the higher bit of the pair and lane 0 the lower bit.
- R3: In four-lane mode a byte takes two rising edges, each carrying one nibble with lane 3 as its MSB. The high nibble comes first.
- R4: Opcode 0x3B selects two-lane mode and opcode 0x38 selects four-lane mode. `lane_mode` reads 0 for one lane, 1 for two lanes and 2 for four lanes. The new width applies from the next select.
- R5: Opcode 0xFF returns the block to one-lane mode. It is accepted at the width in use: four clocks of all-ones in two-lane mode, two clocks in four-lane mode.
- R6: Reset puts the block in one-lane mode. Raising the select line does not change the lane mode.
- R7: Opcode 0x03 is a read. In one-lane mode the first data bit appears on lane 1 after the falling serial edge that follows the last address bit. Bits go MSB first, and `tx_load` pulses once each time a byte from `tx_byte` is taken.
- R8: For a read in two-lane or four-lane mode, one full byte period of serial clocks passes after the address with nothing driven. Data then goes out on lanes 1:0 (two-lane) or lanes 3:0 (four-lane), in the bit order of R2 and R3.
- R9: While select is high, `sio_oe` is 0. A byte cut short by select rising is thrown away, and the next select starts again with an opcode byte.
- R10: After reset the block ignores all traffic until it has seen select go from high to low.
- R11: Lanes are driven only in the data phase of a read, and only the lanes of the current width. During opcode, address, dummy and write-data bytes `sio_oe` is 0.
- R12: Every opcode other than a mode opcode is followed by two address bytes. When the opcode is not a read, each byte after the address is strobed as write data.

Each serial clock level must last at least SYNC_STAGES+2 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| sio_in | input | 4 | Sampled levels of the four data lanes |
| sio_out | output | 4 | Values driven onto the lanes |
| sio_oe | output | 4 | Per-lane output enable |
| rx_data | output | 8 | Last assembled byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_phase | output | 3 | Phase code of the strobed byte (0 opcode, 1 address, 4 write data) |
| tx_byte | input | 8 | Next byte to send during a read |
| tx_load | output | 1 | Pulse when tx_byte has been taken |
| lane_mode | output | 2 | Current lane width code |

## Verification
The bench goes after the width switches. It checks that an exit opcode sent at two-lane or four-lane width is recognised; a design that reassembles it at one-lane width would stay stuck in the wide mode. It counts the dummy period on wide reads, where an off-by-one slot would shift every data byte by a nibble or a whole byte. It also checks the lane bit order; a swap shows up as bit-reversed pairs or nibbles. Select is dropped part way through a byte and then raised again, where a leftover bit count would corrupt the next opcode. Traffic is also sent before any select edge has been seen, and a block that arms too early would strobe that traffic to the core.

// File: rtl/mlsio_pkg.sv
package mlsio_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LW_X1 = 2'd0,
    LW_X2 = 2'd1,
    LW_X4 = 2'd2
  } lane_w_e;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_RDATA = 3'd3,
    PH_WDATA = 3'd4,
    PH_SKIP  = 3'd5
  } phase_e;

  // index of the final serial beat of a byte at a given width
  function automatic logic [2:0] last_beat(lane_w_e w);
    case (w)
      LW_X1:   return 3'd7;
      LW_X2:   return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  // lanes that carry read data at a given width
  function automatic logic [LANES-1:0] lane_mask(lane_w_e w);
    case (w)
      LW_X1:   return 4'b0010;
      LW_X2:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/mlsio_sync.sv
module mlsio_sync #(
  parameter int         WIDTH   = 6,
  parameter int         STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      q_prev <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      q_prev <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mlsio_rx.sv
module mlsio_rx
  import mlsio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              sck_rise,
  input  logic [LANES-1:0]  din,
  input  lane_w_e           lane_w,
  output logic [2:0]        beat,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);

  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_nxt;
  logic [2:0]        last;

  assign last = last_beat(lane_w);

  // MSB-first assembly; the highest-numbered active lane holds the higher bit
  always_comb begin
    case (lane_w)
      LW_X1:   sh_nxt = {sh[BYTE_W-2:0], din[0]};
      LW_X2:   sh_nxt = {sh[BYTE_W-3:0], din[1], din[0]};
      default: sh_nxt = {sh[BYTE_W-5:0], din[3:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      beat      <= '0;
      sh        <= '0;
      byte_done <= 1'b0;
      if (rst) byte_val <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        sh <= sh_nxt;
        if (beat == last) begin
          beat      <= '0;
          byte_done <= 1'b1;
          byte_val  <= sh_nxt;
        end else begin
          beat <= beat + 3'd1;
        end
      end
    end
  end

  assert_done_on_boundary_R1: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (beat == 3'd0));

  assert_beat_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    beat <= last);

endmodule

// File: rtl/mlsio_ctrl.sv
module mlsio_ctrl
  import mlsio_pkg::*;
#(
  parameter logic [7:0] OP_READ    = 8'h03,
  parameter logic [7:0] OP_DUAL    = 8'h3B,
  parameter logic [7:0] OP_QUAD    = 8'h38,
  parameter logic [7:0] OP_EXIT    = 8'hFF,
  parameter int         ADDR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              active,
  output phase_e            phase,
  output lane_w_e           lane_w,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output phase_e            rx_phase
);

  localparam int ACW = $clog2(ADDR_BYTES + 1);

  logic           armed;
  logic [ACW-1:0] addr_cnt;
  logic           is_rd;
  logic           is_mode_op;

  assign active     = armed && !cs_s;
  assign is_mode_op = (byte_val == OP_DUAL) || (byte_val == OP_QUAD) ||
                      (byte_val == OP_EXIT);

  // armed only by an observed select falling edge
  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (cs_s)    armed <= 1'b0;
    else if (cs_fall) armed <= 1'b1;
  end

  // lane width: persists across deselect
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_w <= LW_X1;
    end else if (active && byte_done && phase == PH_CMD) begin
      if (byte_val == OP_DUAL)      lane_w <= LW_X2;
      else if (byte_val == OP_QUAD) lane_w <= LW_X4;
      else if (byte_val == OP_EXIT) lane_w <= LW_X1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
    end else if (active && byte_done) begin
      rx_data <= byte_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase    <= PH_CMD;
      addr_cnt <= '0;
      is_rd    <= 1'b0;
      rx_valid <= 1'b0;
      rx_phase <= PH_CMD;
    end else begin
      rx_valid <= 1'b0;
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            rx_valid <= 1'b1;
            rx_phase <= PH_CMD;
            addr_cnt <= '0;
            is_rd    <= (byte_val == OP_READ);
            phase    <= is_mode_op ? PH_SKIP : PH_ADDR;
          end
          PH_ADDR: begin
            rx_valid <= 1'b1;
            rx_phase <= PH_ADDR;
            if (addr_cnt == ACW'(ADDR_BYTES - 1)) begin
              if (!is_rd)                phase <= PH_WDATA;
              else if (lane_w != LW_X1)  phase <= PH_DUMMY;
              else                       phase <= PH_RDATA;
            end else begin
              addr_cnt <= addr_cnt + 1'b1;
            end
          end
          PH_DUMMY: phase <= PH_RDATA;
          PH_WDATA: begin
            rx_valid <= 1'b1;
            rx_phase <= PH_WDATA;
          end
          default: ;
        endcase
      end
    end
  end

  assert_lane_changes_on_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lane_w) |-> $past(byte_done && phase == PH_CMD));

  assert_deselect_restarts_R9: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (phase == PH_CMD) && !rx_valid);

  assert_strobe_phase_R12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_phase == PH_CMD || rx_phase == PH_ADDR || rx_phase == PH_WDATA));

  assert_no_traffic_unarmed_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !rx_valid);

endmodule

// File: rtl/mlsio_tx.sv
module mlsio_tx
  import mlsio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              sck_fall,
  input  phase_e            phase,
  input  logic [2:0]        beat,
  input  lane_w_e           lane_w,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [LANES-1:0]  sio_out,
  output logic [LANES-1:0]  sio_oe,
  output logic              tx_load
);

  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_shift;
  logic [BYTE_W-1:0] sh_nxt;
  logic [LANES-1:0]  lane_nxt;
  logic              boundary;

  assign boundary = (beat == 3'd0);

  always_comb begin
    case (lane_w)
      LW_X1:   sh_shift = sh << 1;
      LW_X2:   sh_shift = sh << 2;
      default: sh_shift = sh << 4;
    endcase
    sh_nxt = boundary ? tx_byte : sh_shift;
  end

  // per-lane source: the top bits of the next shift value
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (lane_w)
        LW_X1:   lane_nxt[i] = (i == 1) ? sh_nxt[BYTE_W-1] : 1'b0;
        LW_X2:   lane_nxt[i] = (i < 2)  ? sh_nxt[BYTE_W-2+(i%2)] : 1'b0;
        default: lane_nxt[i] = sh_nxt[BYTE_W-4+i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh      <= '0;
      sio_out <= '0;
      sio_oe  <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (sck_fall && phase == PH_RDATA) begin
        sh      <= sh_nxt;
        sio_out <= lane_nxt;
        sio_oe  <= lane_mask(lane_w);
        tx_load <= boundary;
      end
    end
  end

  assert_oe_in_read_R11: assert property (@(posedge clk) disable iff (rst)
    (|sio_oe) |-> (phase == PH_RDATA));

  assert_oe_matches_width_R8: assert property (@(posedge clk) disable iff (rst)
    (|sio_oe) |-> (sio_oe == lane_mask(lane_w)));

  assert_deselect_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    !active |=> (sio_oe == '0));

  assert_load_drives_R7: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (|sio_oe));

endmodule

// File: rtl/mlsio_front.sv
module mlsio_front
  import mlsio_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OP_READ     = 8'h03,
  parameter logic [7:0] OP_DUAL     = 8'h3B,
  parameter logic [7:0] OP_QUAD     = 8'h38,
  parameter logic [7:0] OP_EXIT     = 8'hFF,
  parameter int         ADDR_BYTES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic [2:0] rx_phase,
  input  logic [7:0] tx_byte,
  output logic       tx_load,
  output logic [1:0] lane_mode
);

  localparam int SW = LANES + 2;

  logic [SW-1:0]     s_q, s_p;
  logic              cs_s, sck_rise, sck_fall, cs_fall, active;
  logic [2:0]        beat;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  phase_e            phase, rx_ph;
  lane_w_e           lane_w;

  mlsio_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, sio_in}), .q(s_q), .q_prev(s_p)
  );

  assign cs_s     = s_q[SW-1];
  assign cs_fall  = !s_q[SW-1] &&  s_p[SW-1];
  assign sck_rise =  s_q[SW-2] && !s_p[SW-2];
  assign sck_fall = !s_q[SW-2] &&  s_p[SW-2];

  mlsio_ctrl #(
    .OP_READ(OP_READ), .OP_DUAL(OP_DUAL), .OP_QUAD(OP_QUAD),
    .OP_EXIT(OP_EXIT), .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_s(cs_s), .cs_fall(cs_fall),
    .byte_done(byte_done), .byte_val(byte_val), .active(active),
    .phase(phase), .lane_w(lane_w), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_phase(rx_ph)
  );

  mlsio_rx u_rx (
    .clk(clk), .rst(rst), .active(active), .sck_rise(sck_rise),
    .din(s_q[LANES-1:0]), .lane_w(lane_w), .beat(beat),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  mlsio_tx u_tx (
    .clk(clk), .rst(rst), .active(active), .sck_fall(sck_fall),
    .phase(phase), .beat(beat), .lane_w(lane_w), .tx_byte(tx_byte),
    .sio_out(sio_out), .sio_oe(sio_oe), .tx_load(tx_load)
  );

  assign rx_phase  = rx_ph;
  assign lane_mode = lane_w;

endmodule

// File: tb/test_mlsio_front.sv
module test_mlsio_front;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       cs_n = 1'b0;
  logic [3:0] sio_in = 4'h0;
  logic [7:0] tx_byte = 8'h00;
  logic [3:0] sio_out, sio_oe;
  logic [7:0] rx_data;
  logic       rx_valid, tx_load;
  logic [2:0] rx_phase;
  logic [1:0] lane_mode;

  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  tx_q[$];
  int checks = 0;
  int errors = 0;
  int bw = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlsio_front i_mlsio_front (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_phase(rx_phase), .tx_byte(tx_byte),
    .tx_load(tx_load), .lane_mode(lane_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for strobes, feeder for transmit bytes
  always @(negedge clk) begin
    if (tx_load && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_byte = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    if (!rst && rx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1/R10 unexpected strobe actual=%0h expected=none", {rx_phase, rx_data});
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rx_phase, rx_data} !== e) begin
          errors++;
          $display("FAIL %s strobe actual=%0h expected=%0h", t, {rx_phase, rx_data}, e);
        end
      end
    end
  end

  function automatic int nbeats();
    return (bw == 0) ? 8 : (bw == 1) ? 4 : 2;
  endfunction

  function automatic logic [3:0] width_mask();
    return (bw == 0) ? 4'b0010 : (bw == 1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic beat(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] doe);
    @(negedge clk) sio_in = din;
    repeat (HALF - 1) @(negedge clk);
    dout = sio_out;
    doe  = sio_oe;
    sck  = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit strobe, input logic [2:0] ph, input string tag);
    logic [7:0] s;
    logic [3:0] d, o, din;
    s = b;
    if (strobe) begin
      exp_q.push_back({ph, b});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < nbeats(); i++) begin
      if (bw == 0)      begin din = {3'b0, s[7]}; s = s << 1; end
      else if (bw == 1) begin din = {2'b0, s[7:6]}; s = s << 2; end
      else              begin din = s[7:4]; s = s << 4; end
      beat(din, d, o);
      if (o !== 4'b0000) chk("R11 oe while host drives", o, 0);
    end
  endtask

  task automatic recv(input logic [7:0] exp, input string tag);
    logic [7:0] acc;
    logic [3:0] d, o;
    acc = 8'h00;
    for (int i = 0; i < nbeats(); i++) begin
      beat(4'h0, d, o);
      chk({tag, " oe lanes"}, o, width_mask());
      if (bw == 0)      acc = {acc[6:0], d[1]};
      else if (bw == 1) acc = {acc[5:0], d[1:0]};
      else              acc = {acc[3:0], d};
    end
    chk({tag, " data"}, acc, exp);
  endtask

  task automatic dummy_slot();
    logic [3:0] d, o;
    for (int i = 0; i < nbeats(); i++) begin
      beat(4'hF, d, o);
      chk("R8 dummy slot undriven", o, 0);
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin
    logic [3:0] d, o;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 reset lane mode", lane_mode, 0);
    chk("R9 reset oe", sio_oe, 0);
    chk("R1 reset strobe", rx_valid, 0);

    // R10: select was low through reset, no edge seen
    send(8'h02, 1'b0, 3'd0, "R10");
    send(8'h12, 1'b0, 3'd0, "R10");
    chk("R10 nothing strobed", exp_q.size(), 0);
    desel();

    // R1 / R12: one-lane write
    sel();
    send(8'h02, 1'b1, 3'd0, "R1 opcode");
    send(8'h12, 1'b1, 3'd1, "R12 addr hi");
    send(8'h34, 1'b1, 3'd1, "R12 addr lo");
    send(8'hA5, 1'b1, 3'd4, "R12 wdata0");
    send(8'h5A, 1'b1, 3'd4, "R12 wdata1");
    desel();

    // R9: partial byte dropped
    sel();
    for (int i = 0; i < 5; i++) beat(4'h1, d, o);
    desel();
    sel();
    send(8'h02, 1'b1, 3'd0, "R9 opcode after abort");
    desel();

    // R7: one-lane read, no dummy slot
    tx_q.push_back(8'hC3);
    tx_q.push_back(8'h96);
    sel();
    send(8'h03, 1'b1, 3'd0, "R7 opcode");
    send(8'h00, 1'b1, 3'd1, "R7 addr");
    send(8'h10, 1'b1, 3'd1, "R7 addr");
    recv(8'hC3, "R7 byte0");
    recv(8'h96, "R7 byte1");
    desel();
    chk("R9 oe after deselect", sio_oe, 0);
    chk("R7 tx bytes taken", tx_q.size(), 0);

    // R4: enter two-lane mode; R6: survives deselect
    sel();
    send(8'h3B, 1'b1, 3'd0, "R4 dual opcode");
    desel();
    chk("R4 dual mode", lane_mode, 1);
    chk("R6 mode held over deselect", lane_mode, 1);
    bw = 1;

    // R2: two-lane write
    sel();
    send(8'h02, 1'b1, 3'd0, "R2 opcode");
    send(8'hBE, 1'b1, 3'd1, "R2 addr");
    send(8'h01, 1'b1, 3'd1, "R2 addr");
    send(8'h6C, 1'b1, 3'd4, "R2 wdata");
    desel();

    // R8: two-lane read with dummy slot
    tx_q.push_back(8'hE1);
    sel();
    send(8'h03, 1'b1, 3'd0, "R8 opcode");
    send(8'h40, 1'b1, 3'd1, "R8 addr");
    send(8'h00, 1'b1, 3'd1, "R8 addr");
    dummy_slot();
    recv(8'hE1, "R8 dual byte");
    desel();

    // R5: exit at two-lane width
    sel();
    send(8'hFF, 1'b1, 3'd0, "R5 exit from dual");
    desel();
    chk("R5 exit from dual", lane_mode, 0);
    bw = 0;

    // R4: enter four-lane mode
    sel();
    send(8'h38, 1'b1, 3'd0, "R4 quad opcode");
    desel();
    chk("R4 quad mode", lane_mode, 2);
    bw = 2;

    // R3: four-lane write
    sel();
    send(8'h02, 1'b1, 3'd0, "R3 opcode");
    send(8'h7F, 1'b1, 3'd1, "R3 addr");
    send(8'hE0, 1'b1, 3'd1, "R3 addr");
    send(8'h9D, 1'b1, 3'd4, "R3 wdata0");
    send(8'h42, 1'b1, 3'd4, "R3 wdata1");
    desel();

    // R8: four-lane read
    tx_q.push_back(8'h3C);
    tx_q.push_back(8'h81);
    sel();
    send(8'h03, 1'b1, 3'd0, "R8 quad opcode");
    send(8'hFF, 1'b1, 3'd1, "R8 quad addr");
    send(8'hFF, 1'b1, 3'd1, "R8 quad addr");
    dummy_slot();
    recv(8'h3C, "R8 quad byte0");
    recv(8'h81, "R8 quad byte1");
    desel();

    // R5: exit at four-lane width
    sel();
    send(8'hFF, 1'b1, 3'd0, "R5 exit from quad");
    desel();
    chk("R5 exit from quad", lane_mode, 0);
    bw = 0;

    // R6: reset clears a wide mode
    sel();
    send(8'h3B, 1'b1, 3'd0, "R6 dual before reset");
    desel();
    chk("R6 dual set", lane_mode, 1);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 reset to one lane", lane_mode, 0);

    repeat (10) @(negedge clk);
    chk("R1 all strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule